// File: doc/BRIEF.md
# Pipelined Fixed-Point Divider

This block divides one fixed-point number by another. Each operand has `INT_W` integer bits followed by `FRAC_W` fraction bits, for a total width `W = INT_W + FRAC_W`. The result has the same format. A compile-time parameter chooses two's-complement or unsigned arithmetic. The dividend is first widened and scaled up by `2^FRAC_W`, so the integer quotient of the scaled dividend and the divisor is the fixed-point quotient. The block also produces a remainder on a separate port.

Operand pairs flow through a shift pipeline of `STAGES` slots, two by default. Each cycle in which `go` is high, the pair on `dividend`/`divisor` is loaded and every slot moves one step. A pair that steps out of the last slot is divided, and its result is registered onto `quotient` and `remainder` with `done` high. Dropping `go` empties the pipeline and leaves the outputs as they were. A synchronous reset clears the quotient, `done` and the pipeline, but does not change the remainder register.

Top module: `fxp_divider`

## Requirements
- R1: In unsigned mode, `quotient` equals (`dividend` × 2^FRAC_W) / `divisor`, computed without losing dividend bits and then truncated to the low W bits.
- R2: In unsigned mode, `remainder` equals `dividend` mod `divisor`, using the unscaled dividend.
- R3: In signed mode, operands are two's complement. `quotient` is the low W bits of (`dividend` × 2^FRAC_W) / `divisor`, rounded toward zero.
- R4: In signed mode, `remainder` equals `dividend` − `divisor`·floor(`dividend`/`divisor`). A nonzero remainder has the sign of the divisor.
- R5: A pair presented in a cycle with `go` high produces its results, with `done` high, right after the second following rising edge at which `go` is still high. With `go` held high, one result comes out per cycle.
- R6: At a `go`-high edge where no loaded pair leaves the last slot, `quotient` and `remainder` become zero and `done` becomes low.
- R7: At an edge with `go` low and reset low, the pipeline empties and `done` becomes low, while `quotient` and `remainder` keep their values. Pairs that were in flight never produce a result.
- R8: At a reset edge, `quotient` becomes zero, `done` becomes low and the pipeline empties. `remainder` keeps its value.
- R9: A zero divisor gives an all-ones `quotient` and a `remainder` equal to the dividend. No other indication is raised.
- R10: A scaled dividend whose top bits go past W bits still divides correctly. For example, unsigned 0xFF / 0x10 with FRAC_W=4 gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Load a pair and advance the pipeline this cycle |
| dividend | input | W | Fixed-point dividend |
| divisor | input | W | Fixed-point divisor |
| quotient | output | W | Registered fixed-point quotient |
| remainder | output | W | Registered remainder |
| done | output | 1 | High when the outputs hold the result of a pair |

## Verification
A pair driven before rising edge k has its results visible after edge k+2 if `go` stays high at edges k+1 and k+2. The bench therefore drives inputs on the falling edge and reads the outputs on the falling edge after each rising edge. In a stream, the result checked at step t belongs to the pair driven at step t−2, and steps 0 and 1 after an empty pipeline must read zeros with `done` low. For reset and for lowering `go`, the effect is visible after the very next rising edge: the bench checks the held outputs there, and then checks two bubble cycles once `go` returns. Two instances, one unsigned and one signed, share the same stimulus, so both arithmetic modes are checked on the same cycles.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_state_e;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } div_mode_e;

    // Width of the scaled dividend: sign/guard bit + W + FRAC_W
    function automatic int unsigned scaled_width(input int unsigned w,
                                                 input int unsigned frac);
        return w + frac + 1;
    endfunction

endpackage

// File: rtl/fxdiv_stages.sv
module fxdiv_stages
    import fxdiv_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    output logic         tail_loaded,
    output logic [W-1:0] tail_num,
    output logic [W-1:0] tail_den
);

    typedef struct packed {
        slot_state_e  state;
        logic [W-1:0] num;
        logic [W-1:0] den;
    } slot_t;

    slot_t slot_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            for (int i = 0; i < STAGES; i++) begin
                slot_q[i].state <= SLOT_EMPTY;
            end
        end else begin
            slot_q[0] <= '{state: SLOT_LOADED, num: num_in, den: den_in};
            for (int i = 1; i < STAGES; i++) begin
                slot_q[i] <= slot_q[i-1];
            end
        end
    end

    assign tail_loaded = (slot_q[STAGES-1].state == SLOT_LOADED);
    assign tail_num    = slot_q[STAGES-1].num;
    assign tail_den    = slot_q[STAGES-1].den;

endmodule

// File: rtl/fxdiv_core.sv
module fxdiv_core
    import fxdiv_pkg::*;
#(
    parameter int unsigned INT_W  = 4,
    parameter int unsigned FRAC_W = 4,
    parameter div_mode_e   MODE   = MODE_UNSIGNED
) (
    input  logic [INT_W+FRAC_W-1:0] num,
    input  logic [INT_W+FRAC_W-1:0] den,
    output logic [INT_W+FRAC_W-1:0] quo,
    output logic [INT_W+FRAC_W-1:0] rem
);

    localparam int unsigned W = INT_W + FRAC_W;
    localparam int unsigned E = scaled_width(W, FRAC_W);

    logic den_zero;
    assign den_zero = (den == '0);

    if (MODE == MODE_SIGNED) begin : g_signed
        logic signed [E-1:0] num_sc;
        logic signed [E-1:0] den_sx;
        logic signed [E-1:0] q_wide;
        logic signed [W:0]   a_sx;
        logic signed [W:0]   b_sx;
        logic signed [W:0]   r_trunc;
        logic signed [W:0]   r_floor;

        always_comb begin
            num_sc  = {num[W-1], num, {FRAC_W{1'b0}}};
            den_sx  = den_zero ? E'(1) : {{(FRAC_W+1){den[W-1]}}, den};
            q_wide  = num_sc / den_sx;
            a_sx    = {num[W-1], num};
            b_sx    = den_zero ? (W+1)'(1) : {den[W-1], den};
            r_trunc = a_sx % b_sx;
            r_floor = r_trunc;
            if (r_trunc != '0 && (r_trunc[W] != b_sx[W])) begin
                r_floor = r_trunc + b_sx;
            end
            if (den_zero) begin
                quo = '1;
                rem = num;
            end else begin
                quo = q_wide[W-1:0];
                rem = r_floor[W-1:0];
            end
        end
    end else begin : g_unsigned
        logic [E-1:0] num_sc;
        logic [E-1:0] den_zx;
        logic [E-1:0] q_wide;
        logic [W-1:0] den_safe;

        always_comb begin
            num_sc   = {1'b0, num, {FRAC_W{1'b0}}};
            den_zx   = den_zero ? E'(1) : {{(FRAC_W+1){1'b0}}, den};
            den_safe = den_zero ? W'(1) : den;
            q_wide   = num_sc / den_zx;
            if (den_zero) begin
                quo = '1;
                rem = num;
            end else begin
                quo = q_wide[W-1:0];
                rem = num % den_safe;
            end
        end
    end

endmodule

// File: rtl/fxp_divider.sv
module fxp_divider
    import fxdiv_pkg::*;
#(
    parameter int unsigned INT_W  = 4,
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned STAGES = 2,
    parameter div_mode_e   MODE   = MODE_UNSIGNED
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic [INT_W+FRAC_W-1:0] dividend,
    input  logic [INT_W+FRAC_W-1:0] divisor,
    output logic [INT_W+FRAC_W-1:0] quotient,
    output logic [INT_W+FRAC_W-1:0] remainder,
    output logic                    done
);

    localparam int unsigned W = INT_W + FRAC_W;

    logic         tail_loaded;
    logic [W-1:0] tail_num;
    logic [W-1:0] tail_den;
    logic [W-1:0] core_quo;
    logic [W-1:0] core_rem;

    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic         done_q;

    fxdiv_stages #(
        .W      (W),
        .STAGES (STAGES)
    ) u_stages (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .num_in      (dividend),
        .den_in      (divisor),
        .tail_loaded (tail_loaded),
        .tail_num    (tail_num),
        .tail_den    (tail_den)
    );

    fxdiv_core #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W),
        .MODE   (MODE)
    ) u_core (
        .num (tail_num),
        .den (tail_den),
        .quo (core_quo),
        .rem (core_rem)
    );

    // Quotient and done carry a reset; the remainder register does not.
    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            done_q <= 1'b0;
        end else if (go) begin
            quo_q  <= tail_loaded ? core_quo : '0;
            done_q <= tail_loaded;
        end else begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && go) begin
            rem_q <= tail_loaded ? core_rem : '0;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;
    assign done      = done_q;

endmodule

// File: rtl/fxp_divider_chk.sv
module fxp_divider_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         go,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         done
);

    // R7
    go_low_done_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> !done);

    // R7
    go_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> ($stable(quotient) && $stable(remainder)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (quotient == '0 && !done));

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(go, 1) && $past(go, 2)));

    // R6
    bubble_zero_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> (done || (quotient == '0 && remainder == '0)));

endmodule

bind fxp_divider fxp_divider_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done)
);

// File: tb/sim_fxp_divider.sv
`timescale 1ns/1ps
module sim_fxp_divider;
    import fxdiv_pkg::*;

    localparam int INT_W = 4;
    localparam int FRAC_W = 4;
    localparam int W = INT_W + FRAC_W;
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic [W-1:0] q0, r0, q1, r1;
    logic d0, d1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int pa [16];
    int pb [16];

    always #4 clk = ~clk;

    fxp_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MODE(MODE_UNSIGNED)) u0 (
        .clk(clk), .rst(rst), .go(go), .dividend(dvd), .divisor(dvs),
        .quotient(q0), .remainder(r0), .done(d0));

    fxp_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MODE(MODE_SIGNED)) u1 (
        .clk(clk), .rst(rst), .go(go), .dividend(dvd), .divisor(dvs),
        .quotient(q1), .remainder(r1), .done(d1));

    function automatic int sx(input int v);
        return (v >= (1 << (W-1))) ? v - (1 << W) : v;
    endfunction

    function automatic int exp_uq(input int a, input int b);
        if (b == 0) return MASK;
        return ((a << FRAC_W) / b) & MASK;
    endfunction

    function automatic int exp_ur(input int a, input int b);
        if (b == 0) return a;
        return a % b;
    endfunction

    function automatic int exp_sq(input int a, input int b);
        if (b == 0) return MASK;
        return ((sx(a) * (1 << FRAC_W)) / sx(b)) & MASK;
    endfunction

    function automatic int exp_sr(input int a, input int b);
        int r;
        if (b == 0) return a;
        r = sx(a) % sx(b);
        if (r != 0 && ((r < 0) != (sx(b) < 0))) r = r + sx(b);
        return r & MASK;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Streams pairs pa/pb[0..n-1]; pipeline must be empty on entry.
    task automatic run_stream(input int n, input string tag);
        for (int t = 0; t < n + 2; t++) begin
            int k;
            k = (t < n) ? t : n - 1;
            go  = 1'b1;
            dvd = W'(pa[k]);
            dvs = W'(pb[k]);
            step();
            if (t < 2) begin
                chk({"R6 bubble done ", tag}, int'(d0), 0);
                chk({"R6 bubble quotient ", tag}, int'(q0), 0);
                chk({"R6 bubble remainder ", tag}, int'(r1), 0);
            end else begin
                int i;
                i = t - 2;
                chk({"R5 done unsigned ", tag}, int'(d0), 1);
                chk({"R5 done signed ", tag}, int'(d1), 1);
                chk({"R1 quotient ", tag}, int'(q0), exp_uq(pa[i], pb[i]));
                chk({"R2 remainder ", tag}, int'(r0), exp_ur(pa[i], pb[i]));
                chk({"R3 quotient ", tag}, int'(q1), exp_sq(pa[i], pb[i]));
                chk({"R4 remainder ", tag}, int'(r1), exp_sr(pa[i], pb[i]));
            end
        end
    endtask

    task automatic go_idle();
        go = 1'b0;
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        go  = 1'b1;
        step();
        step();
        chk("R8 reset done", int'(d0), 0);
        chk("R8 reset quotient unsigned", int'(q0), 0);
        chk("R8 reset quotient signed", int'(q1), 0);
        rst = 1'b0;
        go  = 1'b0;
        step();
    endtask

    task automatic t_basic();
        pa[0] = 8'h30; pb[0] = 8'h20;
        pa[1] = 8'h71; pb[1] = 8'h13;
        pa[2] = 8'h98; pb[2] = 8'h30;
        pa[3] = 8'h25; pb[3] = 8'hE8;
        pa[4] = 8'hC3; pb[4] = 8'hD7;
        pa[5] = 8'h10; pb[5] = 8'h70;
        run_stream(6, "mixed");
        go_idle();
    endtask

    task automatic t_wide_and_zero();
        pa[0] = 8'hFF; pb[0] = 8'h10;
        pa[1] = 8'hF0; pb[1] = 8'h20;
        pa[2] = 8'h80; pb[2] = 8'hF0;   // R3 most negative by -1.0
        pa[3] = 8'h5A; pb[3] = 8'h00;   // R9 zero divisor
        pa[4] = 8'hA7; pb[4] = 8'h00;   // R9 zero divisor, negative dividend
        pa[5] = 8'h7F; pb[5] = 8'h01;   // R10 large scaled dividend
        run_stream(6, "R10 R9 corners");
        chk("R9 zero divisor quotient", exp_uq(8'h5A, 0), MASK);
        go_idle();
    endtask

    task automatic t_go_low();
        logic [W-1:0] hq, hr;
        pa[0] = 8'h44; pb[0] = 8'h11;
        pa[1] = 8'h63; pb[1] = 8'h07;
        pa[2] = 8'h9C; pb[2] = 8'h0B;
        run_stream(3, "pre-idle");
        hq = q1;
        hr = r1;
        for (int c = 0; c < 3; c++) begin
            go = 1'b0;
            dvd = 8'h12;
            dvs = 8'h03;
            step();
            chk("R7 idle done low", int'(d1), 0);
            chk("R7 idle quotient held", int'(q1), int'(hq));
            chk("R7 idle remainder held", int'(r1), int'(hr));
        end
        // Pair in flight is discarded when go drops
        go = 1'b1; dvd = 8'h50; dvs = 8'h05;
        step();
        go = 1'b0;
        step();
        chk("R7 flush done low", int'(d0), 0);
        pa[0] = 8'h21; pb[0] = 8'h0C;
        pa[1] = 8'h3B; pb[1] = 8'h17;
        run_stream(2, "R7 after flush");
        go_idle();
    endtask

    task automatic t_reset_midstream();
        logic [W-1:0] hr0, hr1;
        pa[0] = 8'h77; pb[0] = 8'h0D;
        pa[1] = 8'hB5; pb[1] = 8'h29;
        run_stream(2, "pre-reset");
        hr0 = r0;
        hr1 = r1;
        go  = 1'b1;
        rst = 1'b1;
        dvd = 8'h40; dvs = 8'h08;
        step();
        chk("R8 quotient cleared", int'(q0), 0);
        chk("R8 done cleared", int'(d1), 0);
        chk("R8 remainder kept unsigned", int'(r0), int'(hr0));
        chk("R8 remainder kept signed", int'(r1), int'(hr1));
        rst = 1'b0;
        pa[0] = 8'h19; pb[0] = 8'h06;
        pa[1] = 8'hE4; pb[1] = 8'h0A;
        run_stream(2, "R8 after reset");
        go_idle();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_wide_and_zero();
        t_go_low();
        t_reset_midstream();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule